// File: doc/BRIEF.md
# Scalar Single-Precision Maximum with Write Masking

This unit picks the larger of two IEEE-754 single-precision numbers held in the low 32-bit lanes of its operands. It writes the pick into a 128-bit result. The remaining bits of the result come from the first source. The selection is deliberately lopsided. Whenever either input is a NaN, or both inputs are zeros of any sign, the second operand is returned bit for bit. A signalling NaN therefore leaves the unit still signalling.

A two-bit mode input chooses how the low lane of the result is formed:

- Two-operand form: the first source is also the destination.
- Three-operand form: the low lane always takes the maximum.
- Masked three-operand form: a one-bit writemask and a merge/zero select decide the low lane.

Two status flags accompany every result. One reports that some input was a NaN. The other reports that some input was denormal. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `fmax_lane_unit`

## Requirements
- R1: When both low lanes are zero (bits 30:0 all zero, either sign), the low result lane equals `src_b` exactly. A +0/-0 pair returns whichever one sits in `src_b`.
- R2: When `src_a` low lane is a NaN (exponent bits 30:23 all ones, fraction bits 22:0 nonzero), the low result lane equals `src_b`, whatever `src_b` holds.
- R3: When `src_b` is a NaN, the low result lane equals `src_b` bit for bit. A signalling NaN (bit 22 clear) keeps bit 22 clear.
- R4: Otherwise the low result lane is `src_a` only when `src_a` is strictly greater than `src_b`, and `src_b` in every other case. The comparison is sign-magnitude ordering:
  - Infinities are ordinary values.
  - Denormals compare at full value.
  - Any positive value beats any negative one.
- R5: Mode encoding is as follows:
  - 2'b00 is the two-operand form.
  - 2'b01 is the three-operand form.
  - 2'b10 and 2'b11 are the masked form.
  In the masked form with `wmask_bit`=1, the low lane is the maximum. With `wmask_bit`=0, the low lane is `dst_low` when `zero_sel`=0 and 32'h0 when `zero_sel`=1. In the unmasked forms, `wmask_bit` and `zero_sel` have no effect.
- R6: In every mode, result bits 127:32 equal `src_a` bits 127:32. In the two-operand form this keeps the destination's prior upper bits.
- R7: `flag_invalid` is 1 exactly when either input lane is a NaN, quiet or signalling.
- R8: `flag_denorm` is 1 exactly when either input lane is denormal (exponent zero, fraction nonzero).
- R9: Outputs are registered with one clock of latency. While `rst_n` is low, `result`, `flag_invalid` and `flag_denorm` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 128 | First source; its low lane is compared, its upper bits are passed on |
| src_b | input | 32 | Second source lane |
| dst_low | input | 32 | Prior destination low lane, used by merge masking |
| mode | input | 2 | 00 two-operand, 01 three-operand, 1x masked |
| wmask_bit | input | 1 | Writemask bit 0 for the masked form |
| zero_sel | input | 1 | 1 writes zero and 0 keeps `dst_low` when the mask bit is clear |
| result | output | 128 | Registered result vector |
| flag_invalid | output | 1 | Registered NaN-input flag |
| flag_denorm | output | 1 | Registered denormal-input flag |

## Verification
Several input patterns each separate one kind of faulty selection from the correct one:

- Signed-zero pairs in both orders expose any symmetric treatment of zeros.
- Quiet and signalling NaNs in each operand position distinguish "second operand wins" from "NaN wins" and from quietening.
- Negative pairs, mixed-sign pairs, infinities, denormals and equal values probe the sign-magnitude ordering and the strictness of the comparison.

All three mask outcomes, and unmasked modes with the mask inputs toggled, separate the merge, zero and pass-through paths. Randomized vectors drawn from a pool of special encodings then mix these cases in every mode.

// File: rtl/fmax_pkg.sv
// Package: shared types for the scalar maximum unit.
// Assumes binary32-style lanes; field widths are set by the modules' parameters.
package fmax_pkg;

    // Operating modes selected by the two-bit mode input.
    typedef enum logic [1:0] {
        MODE_TWO_OP   = 2'b00,
        MODE_THREE_OP = 2'b01,
        MODE_MASKED   = 2'b10,
        MODE_MASKED_X = 2'b11
    } fmax_mode_e;

    // Classification of one floating-point lane.
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_zero;
        logic is_denorm;
    } fclass_t;

endpackage

// File: rtl/fmax_classify.sv
// Module: fmax_classify
// Classifies one floating-point lane as NaN, zero or denormal and extracts its sign.
// Assumes lane layout {sign, exponent[EXP_W], fraction[FRAC_W]}; purely combinational.
module fmax_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fmax_pkg::fclass_t     cls
);
    localparam int LANE_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = val[LANE_W-2 -: EXP_W];
    assign frac_f = val[FRAC_W-1:0];

    // Decode the exponent/fraction patterns into class bits.
    always_comb begin
        cls.sign      = val[LANE_W-1];
        cls.is_nan    = (&exp_f) & (|frac_f);
        cls.is_zero   = ~(|exp_f) & ~(|frac_f);
        cls.is_denorm = ~(|exp_f) & (|frac_f);
    end
endmodule

// File: rtl/fmax_select.sv
// Module: fmax_select
// Picks the maximum of two lanes with second-operand preference for NaNs and zero pairs.
// Assumes classification comes from fmax_classify; purely combinational.
module fmax_select #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] lane_a,
    input  logic [EXP_W+FRAC_W:0] lane_b,
    input  fmax_pkg::fclass_t     cls_a,
    input  fmax_pkg::fclass_t     cls_b,
    output logic [EXP_W+FRAC_W:0] max_val
);
    localparam int LANE_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = LANE_W - 1;

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             a_greater;
    logic             prefer_b;

    assign mag_a = lane_a[MAG_W-1:0];
    assign mag_b = lane_b[MAG_W-1:0];

    // Strict sign-magnitude greater-than; the zero-pair case is overridden below.
    always_comb begin
        unique case ({cls_a.sign, cls_b.sign})
            2'b01:   a_greater = 1'b1;
            2'b10:   a_greater = 1'b0;
            2'b00:   a_greater = mag_a > mag_b;
            default: a_greater = mag_a < mag_b;
        endcase
    end

    // Second operand wins for any NaN, any zero pair, and every non-strict comparison.
    always_comb begin
        prefer_b = cls_a.is_nan | cls_b.is_nan | (cls_a.is_zero & cls_b.is_zero);
        max_val  = (!prefer_b && a_greater) ? lane_a : lane_b;
    end
endmodule

// File: rtl/fmax_lane_unit.sv
// Module: fmax_lane_unit (top)
// Registered scalar maximum on the low lane of a vector, with mode-dependent
// masking of the low lane and pass-through of the first source's upper bits.
// Assumes VEC_W >= lane width; synchronous active-low reset clears all outputs.
module fmax_lane_unit #(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VEC_W-1:0]         src_a,
    input  logic [EXP_W+FRAC_W:0]    src_b,
    input  logic [EXP_W+FRAC_W:0]    dst_low,
    input  logic [1:0]               mode,
    input  logic                     wmask_bit,
    input  logic                     zero_sel,
    output logic [VEC_W-1:0]         result,
    output logic                     flag_invalid,
    output logic                     flag_denorm
);
    import fmax_pkg::*;

    localparam int LANE_W  = 1 + EXP_W + FRAC_W;
    localparam int UPPER_W = VEC_W - LANE_W;
    localparam int NUM_OPS = 2;

    logic [LANE_W-1:0] op_lane [NUM_OPS];
    fclass_t           op_cls  [NUM_OPS];
    logic [LANE_W-1:0] max_val;
    logic [LANE_W-1:0] lane_next;
    logic [VEC_W-1:0]  result_next;
    logic              invalid_next;
    logic              denorm_next;
    logic              masked;
    fmax_mode_e        mode_e;

    assign op_lane[0] = src_a[LANE_W-1:0];
    assign op_lane[1] = src_b;

    // One classifier per operand lane.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fmax_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (op_lane[g]),
            .cls (op_cls[g])
        );
    end

    fmax_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .lane_a  (op_lane[0]),
        .lane_b  (op_lane[1]),
        .cls_a   (op_cls[0]),
        .cls_b   (op_cls[1]),
        .max_val (max_val)
    );

    assign mode_e = fmax_mode_e'(mode);

    // Decode whether the writemask applies in the current mode.
    always_comb begin
        unique case (mode_e)
            MODE_MASKED, MODE_MASKED_X: masked = 1'b1;
            default:                    masked = 1'b0;
        endcase
    end

    // Form the low lane: maximum, or merge/zero when the mask bit is clear.
    always_comb begin
        if (masked && !wmask_bit)
            lane_next = zero_sel ? '0 : dst_low;
        else
            lane_next = max_val;
    end

    // Assemble the full vector; the upper bits always come from the first source.
    if (UPPER_W > 0) begin : g_upper
        assign result_next = {src_a[VEC_W-1:LANE_W], lane_next};
    end else begin : g_lane_only
        assign result_next = lane_next;
    end

    // Status flags depend only on the input classes.
    always_comb begin
        invalid_next = op_cls[0].is_nan | op_cls[1].is_nan;
        denorm_next  = op_cls[0].is_denorm | op_cls[1].is_denorm;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            result       <= result_next;
            flag_invalid <= invalid_next;
            flag_denorm  <= denorm_next;
        end
    end
endmodule

// File: rtl/fmax_lane_chk.sv
// Module: fmax_lane_chk
// Property checker for fmax_lane_unit, attached with bind below.
// Assumes VEC_W is larger than the lane width.
module fmax_lane_chk #(
    parameter int VEC_W  = 128,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [VEC_W-1:0]      src_a,
    input logic [EXP_W+FRAC_W:0] src_b,
    input logic [EXP_W+FRAC_W:0] dst_low,
    input logic [1:0]            mode,
    input logic                  wmask_bit,
    input logic                  zero_sel,
    input logic [VEC_W-1:0]      result,
    input logic                  flag_invalid,
    input logic                  flag_denorm
);
    localparam int LW = 1 + EXP_W + FRAC_W;

    logic live = 1'b0;
    logic a_nan, b_nan, a_den, b_den, a_zero, b_zero, blocked;

    // Marks cycles whose previous edge loaded real data.
    always_ff @(posedge clk) live <= rst_n;

    // Independent lane decode used by the properties.
    always_comb begin
        a_nan   = (src_a[LW-2:FRAC_W] == '1) && (src_a[FRAC_W-1:0] != '0);
        b_nan   = (src_b[LW-2:FRAC_W] == '1) && (src_b[FRAC_W-1:0] != '0);
        a_den   = (src_a[LW-2:FRAC_W] == '0) && (src_a[FRAC_W-1:0] != '0);
        b_den   = (src_b[LW-2:FRAC_W] == '0) && (src_b[FRAC_W-1:0] != '0);
        a_zero  = src_a[LW-2:0] == '0;
        b_zero  = src_b[LW-2:0] == '0;
        blocked = (mode == 2'b10 || mode == 2'b11) && !wmask_bit;
    end

    assert_zero_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(a_zero && b_zero && !blocked) |-> result[LW-1:0] == $past(src_b));

    assert_a_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(a_nan && !blocked) |-> result[LW-1:0] == $past(src_b));

    assert_b_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(b_nan && !blocked) |-> result[LW-1:0] == $past(src_b));

    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(blocked && zero_sel) |-> result[LW-1:0] == '0);

    assert_merge_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(blocked && !zero_sel) |-> result[LW-1:0] == $past(dst_low));

    assert_upper_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> result[VEC_W-1:LW] == $past(src_a[VEC_W-1:LW]));

    assert_invalid_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> flag_invalid == $past(a_nan || b_nan));

    assert_denorm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> flag_denorm == $past(a_den || b_den));
endmodule

bind fmax_lane_unit fmax_lane_chk #(.VEC_W(VEC_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_a        (src_a),
    .src_b        (src_b),
    .dst_low      (dst_low),
    .mode         (mode),
    .wmask_bit    (wmask_bit),
    .zero_sel     (zero_sel),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_denorm  (flag_denorm)
);

// File: tb/tb_fmax_lane_unit.sv
// Bench: behavioural reference model with an expectation queue, compared each vector.
module tb_fmax_lane_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] src_a;
    logic [31:0]  src_b;
    logic [31:0]  dst_low;
    logic [1:0]   mode;
    logic         wmask_bit;
    logic         zero_sel;
    logic [127:0] result;
    logic         flag_invalid;
    logic         flag_denorm;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [127:0] res;
        logic         inv;
        logic         den;
        string        tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    fmax_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .dst_low(dst_low),
        .mode(mode), .wmask_bit(wmask_bit), .zero_sel(zero_sel),
        .result(result), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
    );

    function automatic bit f_nan(logic [31:0] x);
        return (x & 32'h7f80_0000) == 32'h7f80_0000 && (x & 32'h007f_ffff) != 0;
    endfunction
    function automatic bit f_den(logic [31:0] x);
        return (x & 32'h7f80_0000) == 0 && (x & 32'h007f_ffff) != 0;
    endfunction
    function automatic bit f_zero(logic [31:0] x);
        return (x & 32'h7fff_ffff) == 0;
    endfunction
    // Monotone unsigned key: larger key means larger value (non-NaN inputs).
    function automatic logic [31:0] f_key(logic [31:0] x);
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction
    function automatic logic [31:0] f_max(logic [31:0] a, logic [31:0] b);
        if (f_nan(a) || f_nan(b)) return b;
        if (f_zero(a) && f_zero(b)) return b;
        return (f_key(a) > f_key(b)) ? a : b;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic apply(logic [127:0] a, logic [31:0] b, logic [31:0] d,
                         logic [1:0] m, logic wm, logic zs, string tag);
        exp_t e;
        logic [31:0] lo;
        @(negedge clk);
        src_a = a; src_b = b; dst_low = d; mode = m; wmask_bit = wm; zero_sel = zs;
        if (m[1] && !wm) lo = zs ? 32'h0 : d;
        else             lo = f_max(a[31:0], b);
        e.res = {a[127:32], lo};
        e.inv = f_nan(a[31:0]) || f_nan(b);
        e.den = f_den(a[31:0]) || f_den(b);
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        e = expq.pop_front();
        check(e.tag, {96'h0, result[31:0]}, {96'h0, e.res[31:0]});
        check("R6 upper", {32'h0, result[127:32]}, {32'h0, e.res[127:32]});
        check("R7 invalid", {127'h0, flag_invalid}, {127'h0, e.inv});
        check("R8 denorm", {127'h0, flag_denorm}, {127'h0, e.den});
    endtask

    function automatic logic [31:0] pick(int unsigned i);
        case (i % 16)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h7f80_0001;  3: return 32'hffc0_1234;
            4: return 32'h7f80_0000;  5: return 32'hff80_0000;
            6: return 32'h0000_0001;  7: return 32'h8040_0000;
            8: return 32'h3f80_0000;  9: return 32'hbf80_0000;
            10: return 32'h4000_0000; 11: return 32'hc000_0000;
            12: return 32'h7fc0_0000; 13: return 32'h007f_ffff;
            default: return $urandom;
        endcase
    endfunction

    function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [1:0] m, logic wm);
        if (m[1] && !wm) return "R5";
        if (f_nan(b)) return "R3";
        if (f_nan(a)) return "R2";
        if (f_zero(a) && f_zero(b)) return "R1";
        return "R4";
    endfunction

    function automatic logic [127:0] up(logic [31:0] lo);
        return {$urandom, $urandom, $urandom, lo};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        src_a = {4{32'h7fc0_0000}}; src_b = 32'h0000_0001; dst_low = 32'h1234_5678;
        mode = 2'b01; wmask_bit = 1'b1; zero_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset result", result, 128'h0);
        check("R9 reset flags", {126'h0, flag_invalid, flag_denorm}, 128'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 signed zeros, both orders
        apply(up(32'h0000_0000), 32'h8000_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R1 +0,-0");
        apply(up(32'h8000_0000), 32'h0000_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R1 -0,+0");
        // R2 NaN in first operand
        apply(up(32'h7f80_0001), 32'h3f80_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R2 snan a");
        apply(up(32'h7fc0_0000), 32'hc000_0000, 32'h0, 2'b00, 1'b0, 1'b0, "R2 qnan a");
        // R3 NaN in second operand, kept bit exact and unquieted
        apply(up(32'h3f80_0000), 32'hff80_0005, 32'h0, 2'b01, 1'b1, 1'b0, "R3 snan b");
        apply(up(32'h7fc0_0001), 32'hffc0_0002, 32'h0, 2'b01, 1'b1, 1'b0, "R3 qnan both");
        apply(up(32'h7f80_0000), 32'h7f80_0003, 32'h0, 2'b00, 1'b1, 1'b1, "R3 inf,snan");
        // R4 ordering
        apply(up(32'h7f80_0000), 32'h7f7f_ffff, 32'h0, 2'b01, 1'b1, 1'b0, "R4 +inf");
        apply(up(32'hff80_0000), 32'hbf80_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R4 -inf");
        apply(up(32'h0000_0002), 32'h0000_0001, 32'h0, 2'b01, 1'b1, 1'b0, "R4 denorms");
        apply(up(32'h8000_0001), 32'h0000_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R4 -den,+0");
        apply(up(32'h0000_0000), 32'h8000_0001, 32'h0, 2'b01, 1'b1, 1'b0, "R4 +0,-den");
        apply(up(32'h4040_0000), 32'h4040_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R4 equal");
        apply(up(32'hbf80_0000), 32'hc000_0000, 32'h0, 2'b01, 1'b1, 1'b0, "R4 negatives");
        apply(up(32'h4000_0000), 32'hc040_0000, 32'h0, 2'b00, 1'b1, 1'b0, "R4 mixed sign");
        apply(up(32'h3f00_0000), 32'h3f80_0000, 32'h0, 2'b00, 1'b1, 1'b0, "R4 b larger");
        // R5 mask outcomes and ignored mask inputs in unmasked modes
        apply(up(32'h4000_0000), 32'h3f80_0000, 32'hdead_beef, 2'b10, 1'b1, 1'b1, "R5 mask set");
        apply(up(32'h4000_0000), 32'h3f80_0000, 32'hdead_beef, 2'b10, 1'b0, 1'b0, "R5 merge");
        apply(up(32'h4000_0000), 32'h3f80_0000, 32'hdead_beef, 2'b10, 1'b0, 1'b1, "R5 zero");
        apply(up(32'h7f80_0001), 32'h0000_0003, 32'hcafe_f00d, 2'b11, 1'b0, 1'b0, "R5 merge m11");
        apply(up(32'h4000_0000), 32'h3f80_0000, 32'hdead_beef, 2'b01, 1'b0, 1'b1, "R5 unmasked");
        apply(up(32'h4000_0000), 32'h3f80_0000, 32'hdead_beef, 2'b00, 1'b0, 1'b0, "R5 two-op");

        // Randomized mix of special encodings in every mode
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic [1:0]  rm;
            logic        rw;
            ra = pick($urandom); rb = pick($urandom);
            rm = 2'($urandom); rw = 1'($urandom);
            apply(up(ra), rb, $urandom, rm, rw, 1'($urandom), tag_of(ra, rb, rm, rw));
        end

        // R9 reset again clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 re-reset", {result[127:0]}, 128'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule